// File: doc/BRIEF.md
# Asynchronous Serial Port with Power and Enable Gating

This block is a byte-oriented asynchronous serial transmitter and receiver that a host drives over a small byte-wide register bus. A mode register holds a master power bit, separate transmit and receive enables, and the frame format: the parity mode, the character length and the stop length. A status register reports whether the transmitter is busy, whether the receive buffer holds a byte, and any parity, framing or overrun errors. Writing the transmit data address starts a frame. Reading the receive data address returns the last received byte.

Turning the power bit off holds the whole serial core in reset. The baud divider stops, the transmit shift register, the receive buffer and the error flags clear at once, and the receive line is seen as idle. Each enable bit resets only its own half of the core, on the clock. The register logic enforces the start ordering. An enable can only be set while power is already on, and clearing power also drops both enables.

The receiver uses 16x oversampling and samples each bit at its middle. A start bit is accepted only after the line has been seen high, so a line held low does not produce back-to-back frames.

Top module: `serial_port`

## Requirements
- R1: After reset the mode register reads 0x01, the status register reads 0x00, the receive data register reads 0x00 and tx_o is high.
- R2: Mode bits are [7] power, [6] transmit enable, [5] receive enable, [4:3] parity, [2] character length, [1] stop length, and [0] always reads 1. A write that sets an enable while power currently reads 0 leaves that enable at 0. A write with bit 7 at 0 clears both enables.
- R3: Clearing the power bit ends any frame in flight at once (tx_o high by the next cycle) and clears the receive buffer, the buffer-full flag and all error flags.
- R4: While power is off, activity on rx_i produces no received byte once the port is powered and enabled again.
- R5: A transmitted frame is a low start bit, then the data bits LSB first (7 bits when mode bit 2 is 0, 8 bits when it is 1), then an optional parity bit, then high stop bits. Each bit lasts 16 × BAUD_DIV clock cycles.
- R6: Parity mode 00 sends no parity bit. Mode 01 sends a 0 and the receiver does not check it. Mode 10 gives odd parity and mode 11 gives even parity, both taken over the data bits of the selected length.
- R7: Mode bit 1 at 0 sends one stop bit and at 1 sends two. Status bit 7 (busy) stays high for the whole frame, stop bits included.
- R8: A received byte is placed in the receive data register (bit 7 is 0 in 7-bit mode) and sets status bit 6. Reading the receive data register clears bit 6.
- R9: Status bit 2 flags a parity mismatch in modes 10 and 11, and status bit 1 flags a low first stop bit. Reading the status register clears bits 2..0.
- R10: A byte that completes while status bit 6 is set sets status bit 0 (overrun) and replaces the buffered byte.
- R11: Clearing transmit enable aborts only the transmitter, and clearing receive enable drops only the frame being received. The other half carries on undisturbed.
- R12: A write to the transmit data address is ignored while transmit enable is 0 or a frame is in progress.
- R13: tx_o is high whenever transmit enable or power is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Register address: 0 mode, 1 status, 2 transmit data, 3 receive data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe; side effects take place on the clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |

## Verification
The embedded assertions check the rules that hold on every cycle. Enables never stand while power is off, and everything the power bit clears stays clear while it is off. A transmit load only reaches an idle transmitter, and a disabled transmitter holds the line high. A disabled receiver never reports a byte, and a status or buffer read clears its flags on the next cycle.

Frame bit order, parity values, stop-bit duration, overrun replacement, and the independence of the two halves when one enable drops mid-frame depend on whole serial sequences. Only the bench's scenarios can show these, with the scoreboard decoding tx_o against the expected frames and with receive frames driven on rx_i.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ZERO = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_EVEN = 2'b11
  } par_e;

  typedef struct packed {
    par_e par;
    logic len8;
    logic stop2;
  } fmt_t;

  localparam logic [1:0] A_MODE = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_TXD  = 2'd2;
  localparam logic [1:0] A_RXD  = 2'd3;

  // start + 8 data + parity + 2 stop
  localparam int FRAME_MAX = 12;

  function automatic logic data_xor(logic [7:0] d, logic len8);
    return len8 ? ^d : ^d[6:0];
  endfunction

  function automatic logic par_bit(par_e m, logic [7:0] d, logic len8);
    case (m)
      PAR_ODD:  return ~data_xor(d, len8);
      PAR_EVEN: return data_xor(d, len8);
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/sp_baud.sv
module sp_baud #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);

  generate
    if (DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_cnt
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = (cnt_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/sp_tx.sv
module sp_tx
  import serial_port_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       tick_i,
  input  logic       load_i,
  input  logic [7:0] data_i,
  input  fmt_t       fmt_i,
  output logic       tx_o,
  output logic       busy_o
);

  localparam int OW = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int NW = $clog2(FRAME_MAX + 1);
  localparam logic [OW-1:0] OS_LAST = OW'(OSR - 1);

  logic [FRAME_MAX-1:0] sh_q, frame_d;
  logic [NW-1:0]        left_q, len_d;
  logic [OW-1:0]        os_q;
  logic                 busy_q;

  // whole frame built at load, shifted out LSB first, ones fill behind
  always_comb begin
    int n;
    frame_d    = '1;
    frame_d[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i < 7 || fmt_i.len8) frame_d[1+i] = data_i[i];
    end
    n = fmt_i.len8 ? 10 : 9;
    if (fmt_i.par != PAR_NONE) begin
      frame_d[fmt_i.len8 ? 9 : 8] = par_bit(fmt_i.par, data_i, fmt_i.len8);
      n = n + 1;
    end
    if (fmt_i.stop2) n = n + 1;
    len_d = NW'(n);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
      os_q   <= '0;
    end else if (!en_i) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
      os_q   <= '0;
    end else if (!busy_q) begin
      if (load_i) begin
        sh_q   <= frame_d;
        left_q <= len_d;
        os_q   <= '0;
        busy_q <= 1'b1;
      end
    end else if (tick_i) begin
      if (os_q == OS_LAST) begin
        os_q   <= '0;
        sh_q   <= {1'b1, sh_q[FRAME_MAX-1:1]};
        left_q <= left_q - 1'b1;
        if (left_q == NW'(1)) busy_q <= 1'b0;
      end else begin
        os_q <= os_q + 1'b1;
      end
    end
  end

  assign tx_o   = busy_q ? sh_q[0] : 1'b1;
  assign busy_o = busy_q;

  AST_TX_LOAD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_q); // R12

  AST_TX_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> tx_o); // R13

endmodule

// File: rtl/sp_rx.sv
module sp_rx
  import serial_port_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       tick_i,
  input  logic       rx_i,
  input  fmt_t       fmt_i,
  output logic       done_o,
  output logic [7:0] data_o,
  output logic       perr_o,
  output logic       ferr_o
);

  localparam int OW = (OSR > 1) ? $clog2(OSR) : 1;
  localparam logic [OW-1:0] OS_LAST = OW'(OSR - 1);
  localparam logic [OW-1:0] OS_MID  = OW'((OSR / 2) - 2);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} rx_st_e;

  rx_st_e     st_q;
  logic [OW-1:0] os_q;
  logic [2:0] idx_q;
  logic [7:0] dat_q;
  logic       prev_q, done_q, perr_q, ferr_q;
  logic       bit_end;
  logic [2:0] last_idx;

  assign bit_end  = (os_q == OS_LAST);
  assign last_idx = fmt_i.len8 ? 3'd7 : 3'd6;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      os_q   <= '0;
      idx_q  <= '0;
      dat_q  <= '0;
      prev_q <= 1'b1;
      done_q <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
    end else if (!en_i) begin
      st_q   <= S_IDLE;
      os_q   <= '0;
      idx_q  <= '0;
      prev_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick_i) begin
        case (st_q)
          S_IDLE: begin
            prev_q <= rx_i;
            // armed only after a high sample
            if (prev_q && !rx_i) begin
              st_q <= S_START;
              os_q <= '0;
            end
          end
          S_START: begin
            if (os_q == OS_MID) begin
              os_q <= '0;
              if (!rx_i) begin
                st_q   <= S_DATA;
                idx_q  <= '0;
                dat_q  <= '0;
                perr_q <= 1'b0;
              end else begin
                st_q   <= S_IDLE;
                prev_q <= 1'b1;
              end
            end else begin
              os_q <= os_q + 1'b1;
            end
          end
          S_DATA: begin
            os_q <= bit_end ? '0 : os_q + 1'b1;
            if (bit_end) begin
              dat_q[idx_q] <= rx_i;
              if (idx_q == last_idx) begin
                idx_q <= '0;
                st_q  <= (fmt_i.par != PAR_NONE) ? S_PAR : S_STOP;
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end
          end
          S_PAR: begin
            os_q <= bit_end ? '0 : os_q + 1'b1;
            if (bit_end) begin
              perr_q <= (fmt_i.par == PAR_ODD || fmt_i.par == PAR_EVEN) &&
                        (rx_i != par_bit(fmt_i.par, dat_q, fmt_i.len8));
              st_q   <= S_STOP;
            end
          end
          S_STOP: begin
            os_q <= bit_end ? '0 : os_q + 1'b1;
            if (bit_end) begin
              ferr_q <= !rx_i;
              done_q <= 1'b1;
              prev_q <= rx_i;
              st_q   <= S_IDLE;
            end
          end
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  assign done_o = done_q;
  assign data_o = dat_q;
  assign perr_o = perr_q;
  assign ferr_o = ferr_q;

  AST_RX_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !done_o); // R11

endmodule

// File: rtl/serial_port.sv
module serial_port
  import serial_port_pkg::*;
#(
  parameter int BAUD_DIV = 4,
  parameter int OSR      = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] addr_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       rx_i,
  output logic       tx_o
);

  logic pwr_q, txe_q, rxe_q;
  fmt_t fmt_q;
  logic core_rst_n;

  logic wr_mode, rd_stat, rd_buf, tx_load;
  logic tick, tx_busy;
  logic [1:0] rx_sync_q;
  logic rx_done, rx_perr, rx_ferr;
  logic [7:0] rx_data;

  logic [7:0] rbuf_q;
  logic rfull_q, perr_q, ferr_q, ovr_q;

  logic unused_wdata;
  assign unused_wdata = wdata_i[0];

  assign wr_mode = wr_i && (addr_i == A_MODE);
  assign rd_stat = rd_i && (addr_i == A_STAT);
  assign rd_buf  = rd_i && (addr_i == A_RXD);
  assign tx_load = wr_i && (addr_i == A_TXD) && txe_q && !tx_busy;

  // enables accepted only with power already on
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_q <= 1'b0;
      txe_q <= 1'b0;
      rxe_q <= 1'b0;
      fmt_q <= '0;
    end else if (wr_mode) begin
      pwr_q <= wdata_i[7];
      txe_q <= wdata_i[7] && pwr_q && wdata_i[6];
      rxe_q <= wdata_i[7] && pwr_q && wdata_i[5];
      fmt_q <= fmt_t'(wdata_i[4:1]);
    end
  end

  // power bit doubles as the core's asynchronous reset
  assign core_rst_n = rst_ni & pwr_q;

  always_ff @(posedge clk_i or negedge core_rst_n) begin
    if (!core_rst_n) rx_sync_q <= 2'b11;
    else             rx_sync_q <= {rx_sync_q[0], rx_i};
  end

  sp_baud #(.DIV(BAUD_DIV)) u_baud (
    .clk_i  (clk_i),
    .rst_ni (core_rst_n),
    .tick_o (tick)
  );

  sp_tx #(.OSR(OSR)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (core_rst_n),
    .en_i   (txe_q),
    .tick_i (tick),
    .load_i (tx_load),
    .data_i (wdata_i),
    .fmt_i  (fmt_q),
    .tx_o   (tx_o),
    .busy_o (tx_busy)
  );

  sp_rx #(.OSR(OSR)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (core_rst_n),
    .en_i   (rxe_q),
    .tick_i (tick),
    .rx_i   (rx_sync_q[1]),
    .fmt_i  (fmt_q),
    .done_o (rx_done),
    .data_o (rx_data),
    .perr_o (rx_perr),
    .ferr_o (rx_ferr)
  );

  // a new event wins over a same-cycle clearing read
  always_ff @(posedge clk_i or negedge core_rst_n) begin
    if (!core_rst_n) begin
      rbuf_q  <= '0;
      rfull_q <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (rx_done) rbuf_q <= rx_data;
      rfull_q <= rx_done || (rfull_q && !rd_buf);
      perr_q  <= (perr_q && !rd_stat) || (rx_done && rx_perr);
      ferr_q  <= (ferr_q && !rd_stat) || (rx_done && rx_ferr);
      ovr_q   <= (ovr_q && !rd_stat) || (rx_done && rfull_q && !rd_buf);
    end
  end

  always_comb begin
    case (addr_i)
      A_MODE:  rdata_o = {pwr_q, txe_q, rxe_q, fmt_q, 1'b1};
      A_STAT:  rdata_o = {tx_busy, rfull_q, 3'b000, perr_q, ferr_q, ovr_q};
      A_RXD:   rdata_o = rbuf_q;
      default: rdata_o = 8'h00;
    endcase
  end

  AST_EN_NEEDS_PWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_q |-> (!txe_q && !rxe_q)); // R2

  AST_START_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_mode && !pwr_q) |=> (!txe_q && !rxe_q)); // R2

  AST_PWR_OFF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_q |-> (rbuf_q == 8'h00 && !rfull_q && !perr_q && !ferr_q && !ovr_q && !tx_busy)); // R3

  AST_RXBUF_RD_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_buf && !rx_done && pwr_q) |=> !rfull_q); // R8

  AST_STAT_RD_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat && !rx_done) |=> (!perr_q && !ferr_q && !ovr_q)); // R9

endmodule

// File: tb/serial_port_bench.sv
module serial_port_bench;

  localparam int DIV = 4;
  localparam int OSR = 16;
  localparam int BIT = DIV * OSR;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rx_line = 1'b1;
  logic       tx_line;

  serial_port #(.BAUD_DIV(DIV), .OSR(OSR)) u_serial_port (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .addr_i  (addr),
    .wr_i    (wr),
    .rd_i    (rd),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .rx_i    (rx_line),
    .tx_o    (tx_line)
  );

  int tests = 0;
  int fails = 0;
  bit mon_en = 1'b0;
  bit finished = 1'b0;
  logic [11:0] exp_q[$];
  int          len_q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  function automatic logic [7:0] mode_val(input logic [1:0] par, input logic len8, input logic stop2);
    return 8'hE0 | {3'b0, par, len8, stop2, 1'b0};
  endfunction

  function automatic logic exp_par(input logic [7:0] d, input logic [1:0] par, input logic len8);
    logic x;
    x = len8 ? ^d : ^d[6:0];
    case (par)
      2'b10:   return ~x;
      2'b11:   return x;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [11:0] mk_frame(input logic [7:0] d, input logic [1:0] par,
                                           input logic len8, input logic stop2, output int n);
    logic [11:0] f;
    int k;
    f = '1;
    f[0] = 1'b0;
    k = len8 ? 8 : 7;
    for (int i = 0; i < k; i++) f[1+i] = d[i];
    k = k + 1;
    if (par != 2'b00) begin
      f[k] = exp_par(d, par, len8);
      k = k + 1;
    end
    n = k + (stop2 ? 2 : 1);
    return f;
  endfunction

  task automatic wait_idle(output int cyc);
    logic [7:0] s;
    cyc = 0;
    do begin
      bus_rd(2'd1, s);
      cyc += 2;
    end while (s[7] && cyc < 4000);
  endtask

  task automatic send_tx(input logic [7:0] d, input logic [1:0] par, input logic len8,
                         input logic stop2, input string tag);
    int n, c;
    logic [11:0] f;
    f = mk_frame(d, par, len8, stop2, n);
    exp_q.push_back(f);
    len_q.push_back(n);
    bus_wr(2'd2, d);
    wait_idle(c);
    chk(tag, 32'(c >= n * BIT - 8 && c <= n * BIT + 8), 32'd1);
  endtask

  task automatic send_rx(input logic [7:0] d, input logic len8, input logic [1:0] par,
                         input logic flip, input logic stopv);
    int k;
    k = len8 ? 8 : 7;
    rx_line = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < k; i++) begin
      rx_line = d[i];
      repeat (BIT) @(negedge clk);
    end
    if (par != 2'b00) begin
      rx_line = exp_par(d, par, len8) ^ flip;
      repeat (BIT) @(negedge clk);
    end
    rx_line = stopv;
    repeat (BIT) @(negedge clk);
    rx_line = 1'b1;
    repeat (BIT) @(negedge clk);
  endtask

  // scoreboard monitor: decode tx_o at bit centres
  initial begin
    logic [11:0] got;
    int n;
    forever begin
      @(negedge tx_line);
      if (mon_en) begin
        n = (len_q.size() > 0) ? len_q[0] : 10;
        got = '1;
        repeat (BIT / 2) @(negedge clk);
        got[0] = tx_line;
        for (int i = 1; i < n; i++) begin
          repeat (BIT) @(negedge clk);
          got[i] = tx_line;
        end
        if (exp_q.size() == 0) begin
          chk("R5 unexpected frame", 32'(got), 32'hFFF);
        end else begin
          chk("R5/R6/R7 frame bits", 32'(got), 32'(exp_q.pop_front()));
          void'(len_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int bad;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    bus_rd(2'd0, r); chk("R1 mode reset", r, 8'h01);
    bus_rd(2'd1, r); chk("R1 status reset", r, 8'h00);
    bus_rd(2'd3, r); chk("R1 rxbuf reset", r, 8'h00);
    chk("R1 tx idle", tx_line, 1'b1);

    // R2 enables refused without power
    bus_wr(2'd0, 8'h60);
    bus_rd(2'd0, r); chk("R2 enables ignored while off", r, 8'h01);
    bus_wr(2'd2, 8'h00);
    bad = 0;
    repeat (100) begin @(negedge clk); if (tx_line !== 1'b1) bad++; end
    chk("R13 tx high while off", bad, 0);
    bus_wr(2'd0, 8'h80);
    bus_rd(2'd0, r); chk("R2 power alone", r, 8'h81);
    bus_wr(2'd0, 8'hE0);
    bus_rd(2'd0, r); chk("R2 enables after power", r, 8'hE1);

    // R12 txe off: write ignored
    bus_wr(2'd0, 8'hA4);
    bus_wr(2'd2, 8'h00);
    bad = 0;
    repeat (100) begin @(negedge clk); if (tx_line !== 1'b1) bad++; end
    chk("R12 tx write with txe off", bad, 0);
    bus_rd(2'd1, r); chk("R12 busy with txe off", r[7], 1'b0);

    // transmit scoreboard
    mon_en = 1'b1;
    bus_wr(2'd0, mode_val(2'b00, 1'b1, 1'b0)); send_tx(8'hA5, 2'b00, 1'b1, 1'b0, "R5 8N1 duration");
    bus_wr(2'd0, mode_val(2'b11, 1'b0, 1'b0)); send_tx(8'h35, 2'b11, 1'b0, 1'b0, "R6 7E1 duration");
    bus_wr(2'd0, mode_val(2'b10, 1'b1, 1'b1)); send_tx(8'h3C, 2'b10, 1'b1, 1'b1, "R7 8O2 duration");
    bus_wr(2'd0, mode_val(2'b01, 1'b1, 1'b0)); send_tx(8'hFF, 2'b01, 1'b1, 1'b0, "R6 zero parity duration");
    bus_wr(2'd0, mode_val(2'b11, 1'b1, 1'b1)); send_tx(8'h81, 2'b11, 1'b1, 1'b1, "R7 8E2 duration");
    bus_wr(2'd0, mode_val(2'b00, 1'b0, 1'b0)); send_tx(8'h7F, 2'b00, 1'b0, 1'b0, "R5 7N1 duration");

    // R12 write while busy is dropped
    bus_wr(2'd0, mode_val(2'b00, 1'b1, 1'b0));
    begin
      int n, c;
      logic [11:0] f;
      f = mk_frame(8'h55, 2'b00, 1'b1, 1'b0, n);
      exp_q.push_back(f);
      len_q.push_back(n);
      bus_wr(2'd2, 8'h55);
      bus_wr(2'd2, 8'h0F);
      wait_idle(c);
    end
    repeat (2 * BIT) @(negedge clk);
    chk("R12 no extra frame queued", exp_q.size(), 0);

    // receive
    bus_wr(2'd0, mode_val(2'b00, 1'b1, 1'b0));
    send_rx(8'h5A, 1'b1, 2'b00, 1'b0, 1'b1);
    bus_rd(2'd1, r); chk("R8 full set", r, 8'h40);
    bus_rd(2'd3, r); chk("R8 data", r, 8'h5A);
    bus_rd(2'd1, r); chk("R8 full cleared by read", r, 8'h00);

    bus_wr(2'd0, mode_val(2'b11, 1'b0, 1'b0));
    send_rx(8'h2B, 1'b0, 2'b11, 1'b0, 1'b1);
    bus_rd(2'd1, r); chk("R9 good even parity", r, 8'h40);
    bus_rd(2'd3, r); chk("R8 7-bit data", r, 8'h2B);

    bus_wr(2'd0, mode_val(2'b10, 1'b1, 1'b0));
    send_rx(8'hC4, 1'b1, 2'b10, 1'b1, 1'b1);
    bus_rd(2'd1, r); chk("R9 parity error", r, 8'h44);
    bus_rd(2'd1, r); chk("R9 flags cleared by read", r, 8'h40);
    bus_rd(2'd3, r); chk("R9 data with parity error", r, 8'hC4);

    bus_wr(2'd0, mode_val(2'b00, 1'b1, 1'b0));
    send_rx(8'hA0, 1'b1, 2'b00, 1'b0, 1'b0);
    bus_rd(2'd1, r); chk("R9 framing error", r, 8'h42);
    bus_rd(2'd3, r); chk("R9 data with framing error", r, 8'hA0);

    bus_wr(2'd0, mode_val(2'b01, 1'b1, 1'b0));
    send_rx(8'h3C, 1'b1, 2'b01, 1'b1, 1'b1);
    bus_rd(2'd1, r); chk("R6 zero parity unchecked", r, 8'h40);
    bus_rd(2'd3, r); chk("R6 zero parity data", r, 8'h3C);

    bus_wr(2'd0, mode_val(2'b00, 1'b1, 1'b0));
    send_rx(8'h11, 1'b1, 2'b00, 1'b0, 1'b1);
    send_rx(8'h22, 1'b1, 2'b00, 1'b0, 1'b1);
    bus_rd(2'd1, r); chk("R10 overrun", r, 8'h41);
    bus_rd(2'd3, r); chk("R10 newer byte kept", r, 8'h22);

    // R11 transmitter abort leaves receiver running
    mon_en = 1'b0;
    bus_wr(2'd2, 8'h00);
    fork
      send_rx(8'hC3, 1'b1, 2'b00, 1'b0, 1'b1);
      begin
        repeat (200) @(negedge clk);
        bus_wr(2'd0, 8'hA4);
        repeat (3) @(negedge clk);
        chk("R11 tx line after txe clear", tx_line, 1'b1);
        bus_rd(2'd1, r); chk("R11 tx busy after txe clear", r[7], 1'b0);
      end
    join
    bus_rd(2'd1, r); chk("R11 rx survives tx abort", r, 8'h40);
    bus_rd(2'd3, r); chk("R11 rx data after tx abort", r, 8'hC3);

    // R11 receiver abort leaves transmitter running
    bus_wr(2'd0, 8'hE4);
    mon_en = 1'b1;
    fork
      send_rx(8'h99, 1'b1, 2'b00, 1'b0, 1'b1);
      begin
        int n;
        logic [11:0] f;
        repeat (100) @(negedge clk);
        f = mk_frame(8'h66, 2'b00, 1'b1, 1'b0, n);
        exp_q.push_back(f);
        len_q.push_back(n);
        bus_wr(2'd2, 8'h66);
        repeat (200) @(negedge clk);
        bus_wr(2'd0, 8'hC4);
      end
    join
    begin
      int c;
      wait_idle(c);
    end
    repeat (BIT) @(negedge clk);
    bus_wr(2'd0, 8'hE4);
    bus_rd(2'd1, r); chk("R11 rx abort leaves no byte", r, 8'h00);
    chk("R11 tx frame completed", exp_q.size(), 0);

    // R3 power off mid-frame with pending status
    send_rx(8'hA0, 1'b1, 2'b00, 1'b0, 1'b0);
    mon_en = 1'b0;
    bus_wr(2'd2, 8'h00);
    repeat (100) @(negedge clk);
    bus_wr(2'd0, 8'h00);
    chk("R3 tx line after power off", tx_line, 1'b1);
    bus_rd(2'd0, r); chk("R2 power clear drops enables", r, 8'h01);
    bus_wr(2'd0, 8'h80);
    bus_wr(2'd0, 8'hE4);
    bus_rd(2'd1, r); chk("R3 status cleared", r, 8'h00);
    bus_rd(2'd3, r); chk("R3 rxbuf cleared", r, 8'h00);

    // R4 line activity while off
    bus_wr(2'd0, 8'h00);
    send_rx(8'h00, 1'b1, 2'b00, 1'b0, 1'b1);
    bus_wr(2'd0, 8'h80);
    bus_wr(2'd0, 8'hA4);
    repeat (2 * BIT) @(negedge clk);
    bus_rd(2'd1, r); chk("R4 no byte from off period", r[6], 1'b0);
    bad = 0;
    repeat (50) begin @(negedge clk); if (tx_line !== 1'b1) bad++; end
    chk("R13 tx high with txe off", bad, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule